// File: doc/BRIEF.md
# Flash Translation and Garbage Collection Engine

This block translates host logical addresses into physical (block, page) locations of a small NAND array and keeps that array usable over time. Every host write is appended at a moving write point and is never done in place. The map then points at the new page, and the live-page counters of the new block and of the block that held the superseded copy are both adjusted. Host reads look up the map and fetch the page. An address that has never been written reads back as zero with an unmapped flag.

A per-block table holds an erased flag, an erase counter and a live-page counter. When the write point runs off the end of a block, the next block is opened from among the erased blocks, and the one with the lowest erase count wins. When the number of erased blocks drops to a programmable low-water mark or below, a collector takes over the array. It picks the full block with the fewest live pages, copies each live page to the write point, and erases the emptied block. It repeats this until the erased-block count rises above a high-water mark. Host commands are held off while the collector runs.

The NAND array sits outside the block. Reads return data combinationally, and each program or erase takes one strobe cycle. The configuration must satisfy gc_low_i >= 1, gc_high_i >= gc_low_i, and logical capacity at most (blocks - gc_low_i - 1) * pages.

Top module: `ftl_engine`

## Requirements
- R1: After reset every block is erased: free_blks_o equals the block count, cmd_ready_o is high, and gc_busy_o, rsp_valid_o and all NAND strobes are low.
- R2: A read is accepted on a clock edge where cmd_valid_i and cmd_ready_o are both high. Its response is a one-cycle rsp_valid_o pulse in the second cycle after that edge. For a never-written address the response carries all-zero data and rsp_unmapped_o high.
- R3: A read of a written address returns the data of its most recent write, including after that data has been relocated.
- R4: Only one NAND strobe is active per cycle. Programs within a block go to pages 0, 1, 2 … in order, and never to a page that has been programmed since the block's last erase.
- R5: A block is opened only when it is erased. It is the erased block with the lowest erase count, and the lowest index breaks ties. Each erase adds one to the block's erase count.
- R6: An erase is issued only by the collector, and only for a block with no live page left.
- R7: cmd_ready_o is high only when the erased-block count is above gc_low_i.
- R8: When gc_busy_o falls, the erased-block count is above gc_high_i.
- R9: The block the collector erases held no more live pages when it was chosen than any other full block that was not written during that collection round.
- R10: While gc_busy_o is high, cmd_ready_o stays low. Each relocation reads a live page and programs that page's current data at the write point.
- R11: While cmd_ready_o is high, free_blks_o equals the number of blocks that are erased and not yet reopened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gc_low_i | input | CNT_W | Erased-block count at or below which collection starts |
| gc_high_i | input | CNT_W | Erased-block count that must be exceeded for collection to stop |
| cmd_valid_i | input | 1 | Host command present |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_lba_i | input | LBA_W | Logical address |
| cmd_wdata_i | input | DATA_W | Write data |
| cmd_ready_o | output | 1 | Command accepted on this edge if valid |
| rsp_valid_o | output | 1 | Read response pulse |
| rsp_rdata_o | output | DATA_W | Read data |
| rsp_unmapped_o | output | 1 | Address never written |
| nand_rd_o | output | 1 | NAND page read this cycle |
| nand_prog_o | output | 1 | NAND page program strobe |
| nand_erase_o | output | 1 | NAND block erase strobe |
| nand_blk_o | output | BLK_W | NAND block address |
| nand_page_o | output | PG_W | NAND page address |
| nand_wdata_o | output | DATA_W | Program data |
| nand_rdata_i | input | DATA_W | Read data from the addressed page |
| gc_busy_o | output | 1 | Collection round in progress |
| free_blks_o | output | CNT_W | Number of erased blocks |

## Verification
A corrupted map entry or reverse-map entry shows up at the latest on the next host read of that address, or on the next relocation out of its block, as wrong data or a wrong program address. A wrong live-page count shows up when a later erase hits a block that still holds live data, or when the collector picks a victim that is not the sparsest. A wrong erase count or erased flag shows up at the next block open as a wrong block choice, or as a program into a page that is not erased. The reference model follows every NAND strobe on the cycle it happens, so each of these faults is caught on the cycle it reaches the ports.

// File: rtl/ftl_pkg.sv
package ftl_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_OPEN, S_PROG, S_GC_PICK, S_GC_SCAN, S_GC_ERASE
  } ftl_state_e;
endpackage

// File: rtl/ftl_map.sv
module ftl_map #(
  parameter int NUM_LBAS = 16,
  parameter int PPA_W    = 5,
  localparam int LBA_W   = $clog2(NUM_LBAS),
  localparam int NUM_PPA = 1 << PPA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LBA_W-1:0] lk_lba_i,
  output logic             lk_hit_o,
  output logic [PPA_W-1:0] lk_ppa_o,
  input  logic             upd_en_i,
  input  logic [LBA_W-1:0] upd_lba_i,
  input  logic [PPA_W-1:0] upd_ppa_i,
  input  logic [PPA_W-1:0] q_ppa_i,
  output logic             q_live_o,
  output logic [LBA_W-1:0] q_lba_o
);
  logic [PPA_W-1:0]    l2p_q [NUM_LBAS];
  logic [NUM_LBAS-1:0] mapped_q;
  logic [LBA_W-1:0]    p2l_q [NUM_PPA];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mapped_q <= '0;
      for (int i = 0; i < NUM_LBAS; i++) l2p_q[i] <= '0;
      for (int i = 0; i < NUM_PPA; i++)  p2l_q[i] <= '0;
    end else if (upd_en_i) begin
      l2p_q[upd_lba_i]    <= upd_ppa_i;
      mapped_q[upd_lba_i] <= 1'b1;
      p2l_q[upd_ppa_i]    <= upd_lba_i;
    end
  end

  assign lk_hit_o = mapped_q[lk_lba_i];
  assign lk_ppa_o = l2p_q[lk_lba_i];
  assign q_lba_o  = p2l_q[q_ppa_i];
  // a page is live only if its owner still points back at it
  assign q_live_o = mapped_q[q_lba_o] && (l2p_q[q_lba_o] == q_ppa_i);
endmodule

// File: rtl/ftl_blk_info.sv
module ftl_blk_info #(
  parameter int NUM_BLKS = 8,
  parameter int PAGES    = 4,
  parameter int ECNT_W   = 16,
  localparam int BLK_W   = $clog2(NUM_BLKS),
  localparam int VC_W    = $clog2(PAGES + 1),
  localparam int CNT_W   = $clog2(NUM_BLKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_en_i,
  input  logic [BLK_W-1:0] open_blk_i,
  input  logic             inc_en_i,
  input  logic [BLK_W-1:0] inc_blk_i,
  input  logic             dec_en_i,
  input  logic [BLK_W-1:0] dec_blk_i,
  input  logic             erase_en_i,
  input  logic [BLK_W-1:0] erase_blk_i,
  input  logic             excl_en_i,
  input  logic [BLK_W-1:0] excl_blk_i,
  output logic [CNT_W-1:0] free_cnt_o,
  output logic             alloc_ok_o,
  output logic [BLK_W-1:0] alloc_blk_o,
  output logic             victim_ok_o,
  output logic [BLK_W-1:0] victim_blk_o,
  output logic [VC_W-1:0]  victim_vcnt_o
);
  logic [ECNT_W-1:0]   ecnt_w [NUM_BLKS];
  logic [VC_W-1:0]     vcnt_w [NUM_BLKS];
  logic [NUM_BLKS-1:0] erased_w;

  for (genvar g = 0; g < NUM_BLKS; g++) begin : g_blk
    logic [ECNT_W-1:0] ecnt_q;
    logic [VC_W-1:0]   vcnt_q;
    logic              erased_q;
    logic              inc_hit, dec_hit;

    assign inc_hit = inc_en_i && (inc_blk_i == BLK_W'(g));
    assign dec_hit = dec_en_i && (dec_blk_i == BLK_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ecnt_q   <= '0;
        vcnt_q   <= '0;
        erased_q <= 1'b1;
      end else if (erase_en_i && (erase_blk_i == BLK_W'(g))) begin
        ecnt_q   <= ecnt_q + 1'b1;
        vcnt_q   <= '0;
        erased_q <= 1'b1;
      end else begin
        if (open_en_i && (open_blk_i == BLK_W'(g))) erased_q <= 1'b0;
        vcnt_q <= vcnt_q + VC_W'(inc_hit) - VC_W'(dec_hit);
      end
    end

    assign ecnt_w[g]   = ecnt_q;
    assign vcnt_w[g]   = vcnt_q;
    assign erased_w[g] = erased_q;
  end

  // least-worn erased block, lowest index on ties
  always_comb begin
    logic [ECNT_W-1:0] best_e;
    best_e      = '0;
    alloc_ok_o  = 1'b0;
    alloc_blk_o = '0;
    for (int i = 0; i < NUM_BLKS; i++) begin
      if (erased_w[i] && (!alloc_ok_o || ecnt_w[i] < best_e)) begin
        alloc_ok_o  = 1'b1;
        alloc_blk_o = BLK_W'(i);
        best_e      = ecnt_w[i];
      end
    end
  end

  // sparsest closed block, open block excluded
  always_comb begin
    logic cand;
    victim_ok_o   = 1'b0;
    victim_blk_o  = '0;
    victim_vcnt_o = '0;
    for (int i = 0; i < NUM_BLKS; i++) begin
      cand = !erased_w[i] && !(excl_en_i && excl_blk_i == BLK_W'(i));
      if (cand && (!victim_ok_o || vcnt_w[i] < victim_vcnt_o)) begin
        victim_ok_o   = 1'b1;
        victim_blk_o  = BLK_W'(i);
        victim_vcnt_o = vcnt_w[i];
      end
    end
  end

  always_comb begin
    free_cnt_o = '0;
    for (int i = 0; i < NUM_BLKS; i++) free_cnt_o = free_cnt_o + CNT_W'(erased_w[i]);
  end
endmodule

// File: rtl/ftl_engine.sv
module ftl_engine #(
  parameter int NUM_BLKS = 8,
  parameter int PAGES    = 4,
  parameter int NUM_LBAS = 16,
  parameter int DATA_W   = 16,
  parameter int ECNT_W   = 16,
  localparam int BLK_W   = $clog2(NUM_BLKS),
  localparam int PG_W    = $clog2(PAGES),
  localparam int PPA_W   = BLK_W + PG_W,
  localparam int LBA_W   = $clog2(NUM_LBAS),
  localparam int VC_W    = $clog2(PAGES + 1),
  localparam int CNT_W   = $clog2(NUM_BLKS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  gc_low_i,
  input  logic [CNT_W-1:0]  gc_high_i,
  input  logic              cmd_valid_i,
  input  logic              cmd_write_i,
  input  logic [LBA_W-1:0]  cmd_lba_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  output logic              cmd_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_unmapped_o,
  output logic              nand_rd_o,
  output logic              nand_prog_o,
  output logic              nand_erase_o,
  output logic [BLK_W-1:0]  nand_blk_o,
  output logic [PG_W-1:0]   nand_page_o,
  output logic [DATA_W-1:0] nand_wdata_o,
  input  logic [DATA_W-1:0] nand_rdata_i,
  output logic              gc_busy_o,
  output logic [CNT_W-1:0]  free_blks_o
);
  import ftl_pkg::*;

  ftl_state_e        st_q;
  logic [LBA_W-1:0]  lba_q;
  logic [DATA_W-1:0] data_q;
  logic              from_gc_q;
  logic [BLK_W-1:0]  victim_q;
  logic [PG_W:0]     idx_q;
  logic [BLK_W-1:0]  wp_blk_q;
  logic [PG_W-1:0]   wp_pg_q;
  logic              wp_ok_q;
  logic              gc_active_q;
  logic              rsp_valid_q, rsp_unmapped_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  logic             lk_hit, q_live;
  logic [PPA_W-1:0] lk_ppa, scan_ppa;
  logic [LBA_W-1:0] q_lba;
  logic [CNT_W-1:0] free_cnt;
  logic             alloc_ok, victim_ok;
  logic [BLK_W-1:0] alloc_blk, victim_blk;
  logic [VC_W-1:0]  victim_vcnt;
  logic             gc_go, scan_end;

  assign scan_ppa = {victim_q, idx_q[PG_W-1:0]};
  assign scan_end = (idx_q == (PG_W+1)'(PAGES));

  ftl_map #(.NUM_LBAS(NUM_LBAS), .PPA_W(PPA_W)) map_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lk_lba_i  (lba_q),
    .lk_hit_o  (lk_hit),
    .lk_ppa_o  (lk_ppa),
    .upd_en_i  (st_q == S_PROG),
    .upd_lba_i (lba_q),
    .upd_ppa_i ({wp_blk_q, wp_pg_q}),
    .q_ppa_i   (scan_ppa),
    .q_live_o  (q_live),
    .q_lba_o   (q_lba)
  );

  ftl_blk_info #(.NUM_BLKS(NUM_BLKS), .PAGES(PAGES), .ECNT_W(ECNT_W)) info_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .open_en_i     (st_q == S_OPEN && alloc_ok),
    .open_blk_i    (alloc_blk),
    .inc_en_i      (st_q == S_PROG),
    .inc_blk_i     (wp_blk_q),
    .dec_en_i      (st_q == S_PROG && lk_hit),
    .dec_blk_i     (lk_ppa[PPA_W-1:PG_W]),
    .erase_en_i    (st_q == S_GC_ERASE),
    .erase_blk_i   (victim_q),
    .excl_en_i     (wp_ok_q),
    .excl_blk_i    (wp_blk_q),
    .free_cnt_o    (free_cnt),
    .alloc_ok_o    (alloc_ok),
    .alloc_blk_o   (alloc_blk),
    .victim_ok_o   (victim_ok),
    .victim_blk_o  (victim_blk),
    .victim_vcnt_o (victim_vcnt)
  );

  assign gc_go       = gc_active_q || (free_cnt <= gc_low_i);
  assign cmd_ready_o = (st_q == S_IDLE) && !gc_go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q           <= S_IDLE;
      lba_q          <= '0;
      data_q         <= '0;
      from_gc_q      <= 1'b0;
      victim_q       <= '0;
      idx_q          <= '0;
      wp_blk_q       <= '0;
      wp_pg_q        <= '0;
      wp_ok_q        <= 1'b0;
      gc_active_q    <= 1'b0;
      rsp_valid_q    <= 1'b0;
      rsp_unmapped_q <= 1'b0;
      rsp_rdata_q    <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (gc_go) begin
            gc_active_q <= 1'b1;
            st_q        <= S_GC_PICK;
          end else if (cmd_valid_i) begin
            lba_q     <= cmd_lba_i;
            data_q    <= cmd_wdata_i;
            from_gc_q <= 1'b0;
            if (!cmd_write_i)  st_q <= S_RD;
            else if (wp_ok_q)  st_q <= S_PROG;
            else               st_q <= S_OPEN;
          end
        end
        S_RD: begin
          rsp_valid_q    <= 1'b1;
          rsp_unmapped_q <= !lk_hit;
          rsp_rdata_q    <= lk_hit ? nand_rdata_i : '0;
          st_q           <= S_IDLE;
        end
        S_OPEN: begin
          if (alloc_ok) begin
            wp_blk_q <= alloc_blk;
            wp_pg_q  <= '0;
            wp_ok_q  <= 1'b1;
            st_q     <= S_PROG;
          end
        end
        S_PROG: begin
          wp_pg_q <= wp_pg_q + 1'b1;
          wp_ok_q <= (wp_pg_q != PG_W'(PAGES - 1));
          st_q    <= from_gc_q ? S_GC_SCAN : S_IDLE;
        end
        S_GC_PICK: begin
          if (victim_ok && victim_vcnt < VC_W'(PAGES)) begin
            victim_q <= victim_blk;
            idx_q    <= '0;
            st_q     <= S_GC_SCAN;
          end else begin
            gc_active_q <= 1'b0;
            st_q        <= S_IDLE;
          end
        end
        S_GC_SCAN: begin
          if (scan_end) begin
            st_q <= S_GC_ERASE;
          end else begin
            idx_q <= idx_q + 1'b1;
            if (q_live) begin
              data_q    <= nand_rdata_i;
              lba_q     <= q_lba;
              from_gc_q <= 1'b1;
              st_q      <= wp_ok_q ? S_PROG : S_OPEN;
            end
          end
        end
        S_GC_ERASE: begin
          // round ends once the reclaimed block lifts the count above high water
          gc_active_q <= !(({1'b0, free_cnt} + 1'b1) > {1'b0, gc_high_i});
          st_q        <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    nand_rd_o    = 1'b0;
    nand_prog_o  = 1'b0;
    nand_erase_o = 1'b0;
    nand_blk_o   = '0;
    nand_page_o  = '0;
    nand_wdata_o = data_q;
    unique case (st_q)
      S_RD: begin
        nand_rd_o   = lk_hit;
        nand_blk_o  = lk_ppa[PPA_W-1:PG_W];
        nand_page_o = lk_ppa[PG_W-1:0];
      end
      S_PROG: begin
        nand_prog_o = 1'b1;
        nand_blk_o  = wp_blk_q;
        nand_page_o = wp_pg_q;
      end
      S_GC_SCAN: begin
        nand_rd_o   = !scan_end && q_live;
        nand_blk_o  = victim_q;
        nand_page_o = idx_q[PG_W-1:0];
      end
      S_GC_ERASE: begin
        nand_erase_o = 1'b1;
        nand_blk_o   = victim_q;
      end
      default: ;
    endcase
  end

  assign rsp_valid_o    = rsp_valid_q;
  assign rsp_rdata_o    = rsp_rdata_q;
  assign rsp_unmapped_o = rsp_unmapped_q;
  assign gc_busy_o      = gc_active_q;
  assign free_blks_o    = free_cnt;
endmodule

// File: rtl/ftl_engine_chk.sv
module ftl_engine_chk #(
  parameter int NUM_BLKS = 8,
  parameter int PAGES    = 4,
  parameter int NUM_LBAS = 16,
  parameter int DATA_W   = 16,
  localparam int BLK_W   = $clog2(NUM_BLKS),
  localparam int PG_W    = $clog2(PAGES),
  localparam int LBA_W   = $clog2(NUM_LBAS),
  localparam int CNT_W   = $clog2(NUM_BLKS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  gc_low_i,
  input logic [CNT_W-1:0]  gc_high_i,
  input logic              cmd_ready_o,
  input logic              rsp_valid_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic              rsp_unmapped_o,
  input logic              nand_rd_o,
  input logic              nand_prog_o,
  input logic              nand_erase_o,
  input logic              gc_busy_o,
  input logic [CNT_W-1:0]  free_blks_o
);
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_unmapped_o |-> rsp_rdata_o == '0); // R2
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R2
  AST_ONE_NAND_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({nand_rd_o, nand_prog_o, nand_erase_o}) <= 1); // R4
  AST_ERASE_IN_GC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nand_erase_o |-> gc_busy_o); // R6
  AST_READY_ABOVE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> free_blks_o > gc_low_i); // R7
  AST_GC_STOP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gc_busy_o) |-> free_blks_o > gc_high_i); // R8
  AST_GC_STALLS_HOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gc_busy_o |-> !cmd_ready_o); // R10
  AST_FREE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_blks_o <= CNT_W'(NUM_BLKS)); // R11
endmodule

bind ftl_engine ftl_engine_chk #(
  .NUM_BLKS(NUM_BLKS), .PAGES(PAGES), .NUM_LBAS(NUM_LBAS), .DATA_W(DATA_W)
) chk_i (.*);

// File: tb/ftl_engine_tb_top.sv
`timescale 1ns/1ps
module ftl_engine_tb_top;
  localparam int NB = 8, PG = 4, NL = 16, DW = 16;
  localparam int NPPA = NB * PG;
  localparam logic [DW-1:0] ERASED = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] gc_low = 4'd1, gc_high = 4'd2;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [3:0] cmd_lba = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, rsp_unmapped, nand_rd, nand_prog, nand_erase, gc_busy;
  logic [DW-1:0] rsp_rdata, nand_wdata, nand_rdata;
  logic [2:0] nand_blk;
  logic [1:0] nand_page;
  logic [3:0] free_blks;

  always #2.5 clk = ~clk;

  ftl_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .gc_low_i(gc_low), .gc_high_i(gc_high),
    .cmd_valid_i(cmd_valid), .cmd_write_i(cmd_write), .cmd_lba_i(cmd_lba),
    .cmd_wdata_i(cmd_wdata), .cmd_ready_o(cmd_ready), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .rsp_unmapped_o(rsp_unmapped), .nand_rd_o(nand_rd),
    .nand_prog_o(nand_prog), .nand_erase_o(nand_erase), .nand_blk_o(nand_blk),
    .nand_page_o(nand_page), .nand_wdata_o(nand_wdata), .nand_rdata_i(nand_rdata),
    .gc_busy_o(gc_busy), .free_blks_o(free_blks)
  );

  // behavioural NAND and reference model
  logic [DW-1:0] nand_mem [NPPA];
  assign nand_rdata = nand_mem[{nand_blk, nand_page}];

  int  m_owner [NPPA];
  bit  m_prog  [NPPA];
  int  m_nxt   [NB];
  int  m_ecnt  [NB];
  bit  m_erased[NB];
  bit  m_touch [NB];
  int  m_loc   [NL];
  logic [DW-1:0] m_data [NL];
  int  src_ppa, gc_moves, host_lba;
  bit  prev_busy, done;
  int  n_run = 0, n_fail = 0, cyc = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int live_cnt(int b);
    int n = 0;
    for (int p = 0; p < PG; p++) begin
      int a = b * PG + p;
      if (m_prog[a] && m_owner[a] >= 0 && m_loc[m_owner[a]] == a) n++;
    end
    return n;
  endfunction

  function automatic int model_free();
    int n = 0;
    for (int b = 0; b < NB; b++) if (m_erased[b]) n++;
    return n;
  endfunction

  initial begin
    for (int a = 0; a < NPPA; a++) begin nand_mem[a] = ERASED; m_owner[a] = -1; m_prog[a] = 0; end
    for (int b = 0; b < NB; b++) begin m_nxt[b] = 0; m_ecnt[b] = 0; m_erased[b] = 1; m_touch[b] = 0; end
    for (int l = 0; l < NL; l++) begin m_loc[l] = -1; m_data[l] = '0; end
    src_ppa = 0; gc_moves = 0; host_lba = 0; prev_busy = 0; done = 0;
  end

  // per-cycle monitor of the NAND port
  always @(negedge clk) if (rst_n) begin
    int b, a, lba;
    b = int'(nand_blk);
    a = b * PG + int'(nand_page);
    if (nand_rd) src_ppa = a;
    if (nand_prog) begin
      if (nand_page == 0) begin
        bit best = 1;
        for (int o = 0; o < NB; o++)
          if (o != b && m_erased[o] && (m_ecnt[o] < m_ecnt[b] || (m_ecnt[o] == m_ecnt[b] && o < b))) best = 0;
        check(m_erased[b], "R5", "opened block not erased", b, -1);
        check(best, "R5", "opened block not least worn", b, m_ecnt[b]);
        m_erased[b] = 0;
      end
      check(int'(nand_page) == m_nxt[b] && !m_prog[a], "R4", "program page order", int'(nand_page), m_nxt[b]);
      lba = gc_busy ? m_owner[src_ppa] : host_lba;
      if (gc_busy) begin
        check(lba >= 0 && nand_wdata == m_data[lba], "R10", "relocated data", int'(nand_wdata), lba >= 0 ? int'(m_data[lba]) : -1);
        gc_moves++;
        m_touch[b] = 1;
      end else begin
        check(nand_wdata == m_data[lba], "R3", "host program data", int'(nand_wdata), int'(m_data[lba]));
      end
      nand_mem[a] = nand_wdata;
      m_prog[a] = 1;
      m_owner[a] = lba;
      if (lba >= 0) m_loc[lba] = a;
      m_nxt[b]++;
    end
    if (nand_erase) begin
      check(live_cnt(b) == 0, "R6", "erase of block with live pages", live_cnt(b), 0);
      for (int o = 0; o < NB; o++)
        if (o != b && !m_erased[o] && m_nxt[o] == PG && !m_touch[o])
          check(live_cnt(o) >= gc_moves, "R9", "victim not sparsest", gc_moves, live_cnt(o));
      for (int p = 0; p < PG; p++) begin
        nand_mem[b*PG+p] = ERASED; m_prog[b*PG+p] = 0; m_owner[b*PG+p] = -1;
      end
      m_nxt[b] = 0; m_ecnt[b]++; m_erased[b] = 1;
      gc_moves = 0;
      for (int o = 0; o < NB; o++) m_touch[o] = 0;
    end
    if (cmd_ready) begin
      check(int'(free_blks) == model_free(), "R11", "free block count", int'(free_blks), model_free());
      check(model_free() > int'(gc_low), "R7", "ready at or below low water", model_free(), int'(gc_low) + 1);
      check(!gc_busy, "R10", "ready while collecting", 1, 0);
    end
    if (prev_busy && !gc_busy)
      check(model_free() > int'(gc_high), "R8", "collection stopped early", model_free(), int'(gc_high) + 1);
    if (!gc_busy) begin
      gc_moves = 0;
      for (int o = 0; o < NB; o++) m_touch[o] = 0;
    end
    prev_busy = gc_busy;
  end

  task automatic issue(bit wr, int lba, logic [DW-1:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_lba = 4'(lba); cmd_wdata = d;
    if (wr) begin host_lba = lba; m_data[lba] = d; end
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic do_write(int lba, logic [DW-1:0] d);
    issue(1, lba, d);
  endtask

  task automatic do_read(int lba);
    bit mapped;
    mapped = (m_loc[lba] >= 0);
    issue(0, lba, '0);
    @(negedge clk);
    check(rsp_valid, "R2", "response timing", int'(rsp_valid), 1);
    if (!mapped) begin
      check(rsp_unmapped && rsp_rdata == '0, "R2", "unmapped read", int'(rsp_rdata), 0);
    end else begin
      check(!rsp_unmapped && rsp_rdata == m_data[lba], "R3", "read data", int'(rsp_rdata), int'(m_data[lba]));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(int'(free_blks) == NB, "R1", "free after reset", int'(free_blks), NB);
    check(cmd_ready && !gc_busy && !rsp_valid, "R1", "idle after reset", int'({cmd_ready, gc_busy, rsp_valid}), 4);
    check(!nand_rd && !nand_prog && !nand_erase, "R1", "no nand strobe", int'({nand_rd, nand_prog, nand_erase}), 0);

    do_read(5);   // R2 never written
    do_read(0);
    for (int l = 0; l < NL; l++) do_write(l, DW'(16'h1000 + l * 37));
    for (int l = 0; l < NL; l++) do_read(l);
    do_read(5);

    // uniform overwrites, collection under low=1 high=2
    for (int i = 0; i < 220; i++) begin
      seed = seed * 1103515245 + 12345;
      do_write(int'((seed >> 16) % NL), DW'(i * 131 + 7));
      if (i % 4 == 3) begin
        seed = seed * 1103515245 + 12345;
        do_read(int'((seed >> 16) % NL));
      end
    end

    // hot-spot overwrites under low=2 high=2
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    gc_low = 4'd2; gc_high = 4'd2;
    for (int i = 0; i < 220; i++) begin
      seed = seed * 1103515245 + 12345;
      do_write(int'((seed >> 16) % 3), DW'(16'h8000 + i * 3));
      if (i % 5 == 4) do_read(int'((seed >> 20) % NL));
    end
    for (int l = 0; l < NL; l++) do_read(l);

    repeat (4) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule